// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the transfer datapath of one DMA channel after it has been programmed. A load strobe copies the base address and base count into the current address and count counters and arms the channel. Each accepted transfer strobe then moves the address up by one and the count down by one. The count holds one less than the number of transfers still owed, so a loaded value of zero means one transfer and all ones means 65536 transfers.

The block forms the physical bus address from an 8-bit page value and the 16-bit address counter. In byte mode the page supplies the top eight bits. In word mode the counter is shifted up by one bit, the page supplies only its upper seven bits, and bit 0 of the address is zero. The counter never carries into the page, so a run that crosses a 64K (byte) or 128K (word) boundary wraps inside the same page.

When the count underflows, the block raises a one-cycle terminal-count pulse. With auto-initialization on, the counters reload from the base values and the channel stays armed. With it off, the channel masks itself and ignores transfer strobes until the next load.

Top module: `xfer_addr_count_seq`

## Requirements
- R1: After reset `masked` is 1, `tc` is 0, `residual` is 0 and the address counter is 0.
- R2: A `load` pulse sets the address counter to `base_addr`, `residual` to `base_count` and clears `masked` at the next clock edge. If `xfer` is high in the same cycle, the transfer is dropped and the load wins.
- R3: Each accepted transfer (`xfer` high, `masked` low, `load` low) that does not end the count adds 1 to the address counter modulo 2^16 and subtracts 1 from `residual`.
- R4: When `word_mode` is 0, `phys_addr` is {`page`[7:0], counter[15:0]}.
- R5: When `word_mode` is 1, `phys_addr` is {`page`[7:1], counter[15:0], 1'b0}. The value of `page`[0] has no effect.
- R6: `tc` is high for exactly the one cycle that follows the accepted transfer made while `residual` was 0. A loaded count of N therefore gives N+1 transfers.
- R7: With `auto_init` low, that final transfer sets `masked` and leaves `residual` at 0xFFFF. Later transfer strobes leave the address and `residual` unchanged and raise no `tc`.
- R8: With `auto_init` high, that final transfer reloads the address counter from `base_addr` and `residual` from `base_count`, and `masked` stays low.
- R9: The address counter never carries into the page. A byte run stepping past 0xFFFF keeps the same top eight `phys_addr` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Copy base values into current counters and arm the channel |
| xfer | input | 1 | One pulse per granted transfer |
| auto_init | input | 1 | Reload at terminal count instead of masking |
| word_mode | input | 1 | 1 = word channel, 0 = byte channel |
| base_addr | input | 16 | Base address counter value |
| base_count | input | 16 | Base count (transfers minus one) |
| page | input | 8 | Page value for the upper address bits |
| phys_addr | output | 24 | Physical address of the next transfer |
| tc | output | 1 | Terminal-count pulse |
| residual | output | 16 | Current count (transfers left minus one) |
| masked | output | 1 | Channel is disarmed and ignores transfers |

## Verification
Two functions can land on the same clock edge: a load together with a transfer strobe, and terminal count together with an auto-init reload. The bench drives `load` and `xfer` high in one cycle and expects `residual` to equal the new base with no step applied. It also runs auto-init sweeps in which the final transfer must raise `tc` while `residual` and `phys_addr` return to their base values. Bases of 0 are included, so back-to-back terminal counts with reloads are covered too.

// File: rtl/xfer_addr_count_seq.sv
module xfer_addr_count_seq #(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            xfer,
  input  logic            auto_init,
  input  logic            word_mode,
  input  logic [AW-1:0]   base_addr,
  input  logic [AW-1:0]   base_count,
  input  logic [PW-1:0]   page,
  output logic [AW+PW-1:0] phys_addr,
  output logic            tc,
  output logic [AW-1:0]   residual,
  output logic            masked
);

  logic [AW-1:0] cur_addr, cur_cnt;
  logic acc, last;

  assign acc  = xfer && !masked && !load;
  assign last = (cur_cnt == '0);
  assign residual = cur_cnt;
  assign phys_addr = word_mode ? {page[PW-1:1], cur_addr, 1'b0} : {page, cur_addr};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
      masked   <= 1'b1;
      tc       <= 1'b0;
    end else begin
      tc <= 1'b0;
      if (load) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_count;
        masked   <= 1'b0;
      end else if (acc) begin
        tc <= last;
        if (last && auto_init) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_count;
        end else begin
          cur_addr <= cur_addr + 1'b1;
          cur_cnt  <= cur_cnt - 1'b1;
          if (last) masked <= 1'b1;
        end
      end
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_cnt == $past(base_count)) && (cur_addr == $past(base_addr)) && !masked); // R2
  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !last) |=> (cur_addr == $past(cur_addr) + 1'b1) && (cur_cnt == $past(cur_cnt) - 1'b1)); // R3
  AST_MASK_AT_TC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(masked) |-> tc); // R7
  AST_MASK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (masked && !load) |=> $stable(cur_addr) && $stable(cur_cnt) && !tc); // R7
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && last && auto_init) |=> (cur_cnt == $past(base_count)) && !masked && tc); // R8
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !last && $stable(page) && $stable(word_mode)) |=>
      (phys_addr[AW+PW-1:AW+1] == $past(phys_addr[AW+PW-1:AW+1]))); // R9

endmodule

// File: tb/xfer_addr_count_seq_tb_top.sv
module xfer_addr_count_seq_tb_top;
  logic clk = 0, rst_n = 0, load = 0, xfer = 0, auto_init = 0, word_mode = 0;
  logic [15:0] base_addr = 0, base_count = 0;
  logic [7:0] page = 0;
  logic [23:0] phys_addr;
  logic tc, masked;
  logic [15:0] residual;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xfer_addr_count_seq dut_i (.clk, .rst_n, .load, .xfer, .auto_init, .word_mode,
    .base_addr, .base_count, .page, .phys_addr, .tc, .residual, .masked);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pa(input logic [7:0] pg, input logic [15:0] a, input bit wm);
    return wm ? {pg[7:1], a, 1'b0} : {pg, a};
  endfunction

  task automatic step(input bit x, input bit l);
    xfer = x; load = l;
    @(negedge clk);
    xfer = 0; load = 0;
  endtask

  task automatic check_state(input string tag, input logic [15:0] a, input logic [15:0] c,
                             input bit m, input bit t, input logic [7:0] pg, input bit wm);
    chk(residual == c, {tag, " residual"}, residual, c);
    chk(masked == m, {tag, " masked"}, masked, m);
    chk(tc == t, {tag, " tc"}, tc, t);
    chk(phys_addr == pa(pg, a, wm), {tag, " phys"}, phys_addr, pa(pg, a, wm));
  endtask

  task automatic run(input logic [15:0] ba, input logic [15:0] bc, input logic [7:0] pg,
                     input bit wm, input bit ai);
    base_addr = ba; base_count = bc; page = pg; word_mode = wm; auto_init = ai;
    step(0, 1);
    check_state("R2 load", ba, bc, 0, 0, pg, wm);
    for (int i = 0; i <= int'(bc); i++) begin
      logic [15:0] ea, ec;
      bit fin;
      step(1, 0);
      fin = (i == int'(bc));
      ea = (fin && ai) ? ba : ba + 16'(i + 1);
      ec = (fin && ai) ? bc : bc - 16'(i + 1);
      if (fin) check_state(ai ? "R8 R6 tc reload" : "R7 R6 tc mask", ea, ec, !ai, 1, pg, wm);
      else if (bc < 16'd64 || i % 4096 == 0) check_state("R3 R4 R5 R9 step", ea, ec, 0, 0, pg, wm);
      else chk(tc == 0, "R6 no early tc", tc, 0);
    end
    step(0, 0);
    chk(tc == 0, "R6 single-cycle tc", tc, 0);
    if (!ai) begin
      step(1, 0);
      check_state("R7 ignored after tc", ba + bc + 16'd1, 16'hFFFF, 1, 0, pg, wm);
    end
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check_state("R1 reset", 16'h0, 16'h0, 1, 0, 8'h00, 0);
    step(1, 0);
    check_state("R1 masked at reset ignores xfer", 16'h0, 16'h0, 1, 0, 8'h00, 0);
    rst_n = 1;
    @(negedge clk);
    for (int wm = 0; wm < 2; wm++)
      for (int ai = 0; ai < 2; ai++)
        for (int bc = 0; bc < 6; bc++) begin
          run(16'hFFFD, 16'(bc), 8'h5A + 8'(bc), wm[0], ai[0]);
          run(16'h1230, 16'(bc), 8'hC3, wm[0], ai[0]);
        end
    base_addr = 16'h00FF; base_count = 16'h0004; page = 8'h11; word_mode = 0;
    step(0, 1);
    base_addr = 16'h4000; base_count = 16'h0009;
    step(1, 1);
    check_state("R2 load beats xfer", 16'h4000, 16'h0009, 0, 0, 8'h11, 0);
    word_mode = 1; page = 8'h36;
    @(negedge clk);
    begin
      logic [23:0] p0;
      p0 = phys_addr;
      page = 8'h37;
      #1;
      chk(phys_addr == p0, "R5 page bit0 ignored", phys_addr, p0);
      chk(phys_addr == 24'h368000, "R5 word map", phys_addr, 24'h368000);
    end
    auto_init = 1; base_count = 0; base_addr = 16'h0777;
    step(0, 1);
    step(1, 0);
    check_state("R8 back-to-back tc 1", 16'h0777, 16'h0, 0, 1, 8'h37, 1);
    step(1, 0);
    check_state("R8 back-to-back tc 2", 16'h0777, 16'h0, 0, 1, 8'h37, 1);
    run(16'h8000, 16'hFFFF, 8'hA5, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule